// File: doc/BRIEF.md
# Overlapped Register Exchange Unit

This block swaps a processor's scalar context with a record in memory during a context switch. The context has 27 words: the program counter, the base address that relative word 0 maps to, the program size limit, and eight registers in each of three files (address, index/offset and data). Vector registers are not part of this context, and the unit has no path to them.

The unit does not save the whole context and then restore it. It issues one write and one read per cycle, slot by slot. The write carries the slot's outgoing value to the save record. The read fetches the slot's incoming value from the load record. The read port returns data one cycle after the request, and the unit keeps a request in flight on every cycle. A slot therefore takes its new value two cycles after its request. By then its old value is already held in the write-data register.

The save and load base addresses are sampled together with the start trigger. The unit pulses done once after the last slot has taken its new value. The whole context is visible at all times on a flat output bus.

Top module: `rxu_exchange_unit`

## Requirements
- R1: While reset is high and after it is released, busy, done, both request enables and every context slot read as zero.
- R2: The record layout and the `ctx_q` slot order are the same. Slot 0 is the PC, slot 1 the relative base and slot 2 the limit. Slots 3..10 are address registers 0..7, slots 11..18 are index registers 0..7 and slots 19..26 are data registers 0..7. Slot s occupies `ctx_q[s*DW +: DW]` and lives at record offset s.
- R3: A start sampled while busy is low is accepted. In the cycle after the accepting edge, busy is high and slot 0 is requested on both ports at the two bases just sampled.
- R4: After acceptance, in cycles 0..26, exactly one write and one read are issued in each cycle, with no gap. In cycle s the write goes to save_base+s and the read to load_base+s, both modulo 2^AW.
- R5: The write data for slot s is the value the slot held at the accepting edge. This holds even when the save and load records overlap.
- R6: Slot s takes the word returned one cycle after its read request. The new value is visible from cycle s+2 onward.
- R7: Done is high for exactly cycle 28 after acceptance. Busy is high in cycles 0..27 and low in cycle 28.
- R8: A start that arrives while busy is high has no effect. The exchange in progress keeps its addresses and data.
- R9: A start sampled during the done cycle is accepted, so two exchanges can run back to back.
- R10: Read-port data that arrives with no read outstanding leaves every slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Exchange trigger |
| save_base | input | AW | Base address of the outgoing record |
| load_base | input | AW | Base address of the incoming record |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_wr_en | output | 1 | Write request |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Outgoing slot value |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | DW | Read data, valid one cycle after the request |
| ctx_q | output | 27*DW | Current context, slot s at bits s*DW +: DW |

## Verification
The assertions check on every cycle that an accepted start raises busy together with both requests. They also check that addresses step by one across consecutive requests, with wrap, and that no write appears while idle. Done must be a single-cycle pulse that ends a busy period. Only the bench scenarios can show what the data does: which old value is saved, which new value lands in which slot, and when it lands. The bench also covers correct read-before-write order when the records overlap, an ignored mid-run trigger, a back-to-back restart and junk on an idle read port.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  // Header words that precede the three register files in a record.
  localparam int HDR_SLOTS = 3;
  localparam int SLOT_PC   = 0;
  localparam int SLOT_RBAS = 1;
  localparam int SLOT_LIM  = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_TAIL
  } seq_state_e;

  function automatic int slot_total(input int na, input int nx, input int nd);
    return HDR_SLOTS + na + nx + nd;
  endfunction
endpackage

// File: rtl/rxu_seq.sv
module rxu_seq #(
  parameter int NSLOT = 27,
  parameter int AW    = 10,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] save_base,
  input  logic [AW-1:0] load_base,
  input  logic          last_cap,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [IW-1:0] req_idx,
  output logic          lat_go,
  output logic [IW-1:0] lat_idx
);
  import rxu_pkg::*;

  seq_state_e    state;
  logic [IW-1:0] idx;
  logic [AW-1:0] sb_q, lb_q;
  logic          more;

  assign more = (idx < IW'(NSLOT));
  assign busy = (state != SEQ_IDLE);

  // Slot whose outgoing value is latched into the write-data register at this edge.
  always_comb begin
    lat_go  = ((state == SEQ_IDLE) && start) || ((state == SEQ_RUN) && more);
    lat_idx = (state == SEQ_IDLE) ? '0 : idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      idx     <= '0;
      sb_q    <= '0;
      lb_q    <= '0;
      wr_en   <= 1'b0;
      rd_en   <= 1'b0;
      wr_addr <= '0;
      rd_addr <= '0;
      req_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            sb_q    <= save_base;
            lb_q    <= load_base;
            wr_addr <= save_base;
            rd_addr <= load_base;
            wr_en   <= 1'b1;
            rd_en   <= 1'b1;
            req_idx <= '0;
            idx     <= IW'(1);
            state   <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (more) begin
            wr_addr <= sb_q + AW'(idx);
            rd_addr <= lb_q + AW'(idx);
            req_idx <= idx;
            idx     <= IW'(idx + 1'b1);
          end else begin
            wr_en <= 1'b0;
            rd_en <= 1'b0;
            state <= SEQ_TAIL;
          end
        end
        SEQ_TAIL: begin
          if (last_cap) begin
            done  <= 1'b1;
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxu_rd_track.sv
module rxu_rd_track #(
  parameter int NSLOT = 27,
  parameter int DW    = 64,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [IW-1:0] req_idx,
  input  logic [DW-1:0] rd_data,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx,
  output logic [DW-1:0] cap_data,
  output logic          last_cap
);
  // A request is visible on the port for one cycle; the memory samples it at
  // the following edge and returns data in the cycle after that.
  logic          pend_q;
  logic [IW-1:0] pend_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= rd_en;
      pend_idx_q <= req_idx;
    end
  end

  assign cap_en   = pend_q;
  assign cap_idx  = pend_idx_q;
  assign cap_data = rd_data;
  assign last_cap = pend_q && (pend_idx_q == IW'(NSLOT - 1));
endmodule

// File: rtl/rxu_ctx_file.sv
module rxu_ctx_file #(
  parameter int NSLOT = 27,
  parameter int DW    = 64,
  parameter int IW    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  logic [IW-1:0]       cap_idx,
  input  logic [DW-1:0]       cap_data,
  input  logic [IW-1:0]       rd_idx,
  output logic [DW-1:0]       rd_val,
  output logic [NSLOT*DW-1:0] flat
);
  logic [DW-1:0] slots [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSLOT; k++) slots[k] <= '0;
    end else if (cap_en) begin
      slots[cap_idx] <= cap_data;
    end
  end

  assign rd_val = slots[rd_idx];

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign flat[g*DW +: DW] = slots[g];
  end
endmodule

// File: rtl/rxu_exchange_unit.sv
module rxu_exchange_unit #(
  parameter int DW    = 64,
  parameter int AW    = 10,
  parameter int NUM_A = 8,
  parameter int NUM_X = 8,
  parameter int NUM_D = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [AW-1:0]        save_base,
  input  logic [AW-1:0]        load_base,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_wr_en,
  output logic [AW-1:0]        mem_wr_addr,
  output logic [DW-1:0]        mem_wr_data,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [DW-1:0]        mem_rd_data,
  output logic [rxu_pkg::slot_total(NUM_A, NUM_X, NUM_D)*DW-1:0] ctx_q
);
  localparam int NSLOT = rxu_pkg::slot_total(NUM_A, NUM_X, NUM_D);
  localparam int IW    = $clog2(NSLOT + 1);

  logic          last_cap, lat_go, cap_en;
  logic [IW-1:0] req_idx, lat_idx, cap_idx;
  logic [DW-1:0] cap_data, slot_val;

  rxu_seq #(.NSLOT(NSLOT), .AW(AW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .save_base(save_base), .load_base(load_base), .last_cap(last_cap),
    .busy(busy), .done(done), .wr_en(mem_wr_en), .rd_en(mem_rd_en),
    .wr_addr(mem_wr_addr), .rd_addr(mem_rd_addr), .req_idx(req_idx),
    .lat_go(lat_go), .lat_idx(lat_idx)
  );

  rxu_rd_track #(.NSLOT(NSLOT), .DW(DW), .IW(IW)) u_trk (
    .clk(clk), .rst(rst), .rd_en(mem_rd_en), .req_idx(req_idx),
    .rd_data(mem_rd_data), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(cap_data), .last_cap(last_cap)
  );

  rxu_ctx_file #(.NSLOT(NSLOT), .DW(DW), .IW(IW)) u_ctx (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(cap_data), .rd_idx(lat_idx), .rd_val(slot_val), .flat(ctx_q)
  );

  // Outgoing value is captured two edges before its slot can be overwritten.
  always_ff @(posedge clk) begin
    if (rst)         mem_wr_data <= '0;
    else if (lat_go) mem_wr_data <= slot_val;
  end
endmodule

// File: rtl/rxu_exchange_chk.sv
module rxu_exchange_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_wr_en,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_wr_addr,
  input logic [AW-1:0] mem_rd_addr
);
  // R3
  accept_req_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && mem_wr_en && mem_rd_en));

  // R4
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en || mem_rd_en) |-> busy);

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == AW'($past(mem_wr_addr) + 1'b1)));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == AW'($past(mem_rd_addr) + 1'b1)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind rxu_exchange_unit rxu_exchange_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
  .mem_wr_addr(mem_wr_addr), .mem_rd_addr(mem_rd_addr)
);

// File: tb/rxu_exchange_unit_bench.sv
module rxu_exchange_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 64;
  localparam int AW    = 10;
  localparam int NSLOT = 27;
  localparam int MEMW  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] save_base = '0, load_base = '0;
  logic busy, done, mem_wr_en, mem_rd_en;
  logic [AW-1:0] mem_wr_addr, mem_rd_addr;
  logic [DW-1:0] mem_wr_data;
  logic [DW-1:0] mem_rd_data = '0;
  logic [NSLOT*DW-1:0] ctx_q;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxu_exchange_unit #(.DW(DW), .AW(AW)) u_rxu_exchange_unit (
    .clk(clk), .rst(rst), .start(start), .save_base(save_base), .load_base(load_base),
    .busy(busy), .done(done), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .ctx_q(ctx_q)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return {(32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000, 32'(i) ^ 32'hC0DE0000};
  endfunction

  // Memory with one-cycle read latency; junk appears on the read port when idle.
  logic [DW-1:0] mem [MEMW];
  int junk = 0;
  initial for (int i = 0; i < MEMW; i++) mem[i] = pat(i);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    else begin
      mem_rd_data <= {32'hBAD0BAD0, 32'(junk)};
      junk <= junk + 1;
    end
  end

  // Behavioural reference: t counts cycles since the accepting edge, -1 when idle.
  int t = -1;
  logic [DW-1:0] m_ctx [NSLOT];
  logic [DW-1:0] m_old [NSLOT];
  logic [DW-1:0] m_new [NSLOT];
  logic [AW-1:0] m_sb = '0, m_lb = '0;

  always @(posedge clk) begin
    if (rst) begin
      t = -1;
      for (int k = 0; k < NSLOT; k++) m_ctx[k] = '0;
    end else begin
      if (t >= 0 && t < NSLOT) m_new[t] = mem[m_lb + AW'(t)];
      if (t >= 1 && t <= NSLOT) m_ctx[t-1] = m_new[t-1];
      if (t < 0 || t == NSLOT + 1) begin
        if (start) begin
          t = 0;
          m_sb = save_base;
          m_lb = load_base;
          for (int k = 0; k < NSLOT; k++) m_old[k] = m_ctx[k];
        end else t = -1;
      end else t = t + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] slot(input int k);
    return ctx_q[k*DW +: DW];
  endfunction

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (cyc > 0) begin
      automatic bit   req  = (t >= 0 && t < NSLOT);
      automatic bit   ebsy = (t >= 0 && t <= NSLOT);
      automatic bit   edn  = (t == NSLOT + 1);
      automatic int   bad  = -1;
      chk(busy == ebsy, rst ? "R1 busy" : "R3 busy", DW'(busy), DW'(ebsy));
      chk(done == edn, rst ? "R1 done" : "R7 done", DW'(done), DW'(edn));
      chk(mem_wr_en == req && mem_rd_en == req, "R4 request enables",
          DW'({mem_wr_en, mem_rd_en}), DW'({req, req}));
      if (req) begin
        chk(mem_wr_addr == m_sb + AW'(t), "R4 write address", DW'(mem_wr_addr), DW'(m_sb + AW'(t)));
        chk(mem_rd_addr == m_lb + AW'(t), "R4 read address", DW'(mem_rd_addr), DW'(m_lb + AW'(t)));
        chk(mem_wr_data == m_old[t], "R5 write data", mem_wr_data, m_old[t]);
      end
      for (int k = NSLOT - 1; k >= 0; k--) if (slot(k) !== m_ctx[k]) bad = k;
      if (bad >= 0) chk(1'b0, rst ? "R1 context" : "R6 context slot", slot(bad), m_ctx[bad]);
      else          chk(1'b1, "R6 context", '0, '0);
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic kick(input logic [AW-1:0] sb, input logic [AW-1:0] lb);
    @(negedge clk);
    start = 1'b1; save_base = sb; load_base = lb;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [NSLOT*DW-1:0] snap;
    int b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_wr_en && !mem_rd_en, "R1 reset outputs", DW'({busy, done, mem_wr_en, mem_rd_en}), '0);
    chk(ctx_q == '0, "R1 reset context", slot(0), '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // First exchange: zero context saved, record at 0x200 loaded.
    kick(10'h100, 10'h200);
    wait_done();
    // R2 slot order
    chk(slot(0)  == pat(10'h200), "R2 PC slot", slot(0), pat(10'h200));
    chk(slot(2)  == pat(10'h202), "R2 limit slot", slot(2), pat(10'h202));
    chk(slot(3)  == pat(10'h203), "R2 address reg 0", slot(3), pat(10'h203));
    chk(slot(11) == pat(10'h20B), "R2 index reg 0", slot(11), pat(10'h20B));
    chk(slot(26) == pat(10'h21A), "R2 data reg 7", slot(26), pat(10'h21A));
    chk(mem[10'h10A] == '0, "R5 saved zero", mem[10'h10A], '0);

    // Second exchange with a trigger during the run (R8).
    kick(10'h300, 10'h040);
    repeat (4) @(negedge clk);
    start = 1'b1; save_base = 10'h3F0; load_base = 10'h380;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    b1 = 0;
    for (int k = 0; k < NSLOT; k++) if (mem[10'h300 + k] !== pat(10'h200 + k)) b1++;
    chk(b1 == 0, "R5 saved record", DW'(b1), '0);
    chk(slot(7) == pat(10'h047), "R8 context after ignored start", slot(7), pat(10'h047));
    chk(mem[10'h3F0] == pat(10'h3F0), "R8 ignored save base untouched", mem[10'h3F0], pat(10'h3F0));

    // R9 back-to-back: start while done is high.
    start = 1'b1; save_base = 10'h140; load_base = 10'h080;
    @(negedge clk);
    start = 1'b0;
    chk(busy && mem_wr_addr == 10'h140, "R9 restart on done cycle", DW'({busy, mem_wr_addr}), DW'({1'b1, 10'h140}));
    wait_done();

    // R4 address wrap on the load record.
    kick(10'h2E0, 10'h3F5);
    wait_done();
    chk(slot(10) == pat(10'h3FF), "R4 before wrap", slot(10), pat(10'h3FF));
    chk(slot(11) == pat(10'h000), "R4 after wrap", slot(11), pat(10'h000));
    chk(slot(26) == pat(10'h00F), "R4 last slot wrapped", slot(26), pat(10'h00F));

    // In-place and shifted overlapping records (R5/R6 read-before-write).
    kick(10'h060, 10'h060);
    wait_done();
    chk(slot(5) == pat(10'h065), "R6 in-place swap", slot(5), pat(10'h065));
    kick(10'h0A1, 10'h0A0);
    wait_done();

    // R10 junk on an idle read port.
    @(negedge clk);
    snap = ctx_q;
    repeat (20) @(negedge clk);
    chk(ctx_q == snap, "R10 idle read data ignored", slot(0), snap[DW-1:0]);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule